// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block controls how a small 8-bit processor enters and leaves interrupt service. Each maskable request has its own enable. Three requests are nonmaskable: XIRQ, an illegal-opcode trap and a software interrupt. While the block is idle it waits for the instruction-boundary strobe. At that strobe it checks which requests are allowed through the masks in the live condition code byte and picks one winner by fixed priority. It then writes the processor state onto a byte-wide stack through a single-port memory bus, one byte per cycle. After that it sets the mask bits and reads a two-byte vector for the winner, which becomes the new program counter.

A return command reverses the frame. It reads the nine stacked bytes back in the opposite order and hands the restored register set to the processor. The processor's register file is seen as parallel inputs, which are captured when a sequence starts. The results come back on parallel outputs, and a one-cycle load strobe marks the moment they become valid.

Top module: `irq_stack_seq`

## Requirements
- R1: A maskable request i is taken only when `irq_en[i]` is high and the I bit (bit 4) of `ccr_in` is clear.
- R2: The illegal-opcode and software requests are taken whatever the I bit holds. XIRQ is taken whatever the I bit holds, but only when the X bit (bit 6) of `ccr_in` is clear.
- R3: Entry starts only on a cycle where the block is idle and `insn_done` is high. Requests that are present during a sequence cause nothing until a boundary strobe arrives after the block is idle again.
- R4: Entry makes nine write cycles at addresses SP, SP-1, and so on down to SP-8, where SP is `sp_in` at the boundary. The bytes written, in order, are PC low, PC high, IY low, IY high, IX low, IX high, A, B and CCR. The CCR byte is written with its value at entry.
- R5: After the CCR byte has been written, `ccr_out` has bit 4 set. Bit 6 is also set, but only when the winning source is XIRQ. The other CCR bits keep their entry values.
- R6: The winner is chosen by source index, where the lowest index wins. XIRQ is index 0, the illegal-opcode trap is index 1, the software interrupt is index 2, and maskable request i is index 3+i.
- R7: The vector is read at two addresses. The high byte comes from VEC_BASE + 2·index and the low byte from the next address, in that order. The vector is then loaded as `pc_out` = {high, low}.
- R8: Once the vector is loaded, `reg_load` pulses for one cycle. At that point `sp_out` is the entry SP minus 9, and IX, IY, A and B equal their entry values.
- R9: When the block is idle, `rti_cmd` starts a return. It makes nine read cycles at addresses SP+1 up to SP+9, where SP is `sp_in` at that moment. The bytes go back in the order CCR, B, A, IX high, IX low, IY high, IY low, PC high, PC low. `reg_load` then pulses with `sp_out` = SP+9.
- R10: If `rti_cmd` and an entry condition occur in the same idle cycle, the return is performed.
- R11: `busy` is high for exactly 11 cycles during an entry and exactly 9 cycles during a return. While the block is idle there is no memory access. `mem_we` and `mem_re` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | N_IRQ | Maskable request lines |
| irq_en | input | N_IRQ | Per-line enables |
| xirq_req | input | 1 | Nonmaskable request, gated by the X bit |
| illop_req | input | 1 | Illegal-opcode trap request |
| swi_req | input | 1 | Software interrupt request |
| insn_done | input | 1 | Instruction-boundary strobe |
| rti_cmd | input | 1 | Return-from-interrupt command |
| pc_in | input | 16 | Program counter |
| iy_in | input | 16 | Index register Y |
| ix_in | input | 16 | Index register X |
| a_in | input | 8 | Accumulator A |
| b_in | input | 8 | Accumulator B |
| ccr_in | input | 8 | Condition code byte |
| sp_in | input | AW | Stack pointer |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable |
| mem_re | output | 1 | Read enable; data sampled at the end of the cycle |
| mem_rdata | input | 8 | Read data, same cycle |
| busy | output | 1 | A sequence is in progress |
| reg_load | output | 1 | One-cycle strobe: register outputs are valid |
| pc_out | output | 16 | Resulting program counter |
| iy_out | output | 16 | Resulting IY |
| ix_out | output | 16 | Resulting IX |
| a_out | output | 8 | Resulting A |
| b_out | output | 8 | Resulting B |
| ccr_out | output | 8 | Resulting condition code byte |
| sp_out | output | AW | Resulting stack pointer |

## Verification
The bench targets three kinds of fault. The first is mask gating: a design that ignored the per-line enable, the I bit or the X bit would enter when it should stay idle. The second is ordering: a push frame with its bytes swapped, or a return that pulls in push order, shows up as wrong bytes at the logged addresses and as a round trip that fails to bring back the original registers. The third is priority and timing: these are checked with simultaneous requests, with an XIRQ raised in the middle of a push, which must not start another entry before the next boundary strobe, and with a return command that coincides with a boundary strobe. A design that set the I bit before the CCR write would stack a CCR byte with I already set, and the bench catches that in the logged write data.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;
    localparam int FRAME_BYTES = 9;
    localparam int FB_PCL = 0;
    localparam int FB_PCH = 1;
    localparam int FB_CCR = 8;
    localparam int CCR_I = 4;
    localparam int CCR_X = 6;
    localparam int SRC_XIRQ = 0;
    localparam int SRC_ILL = 1;
    localparam int SRC_SWI = 2;
    localparam int SRC_IRQ0 = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PUSH,
        ST_VEC,
        ST_PULL
    } seq_st_e;
endpackage

// File: rtl/irqseq_arb.sv
module irqseq_arb #(
    parameter int N_IRQ = 8,
    parameter int SRC_W = 4
) (
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             xirq_req,
    input  logic             illop_req,
    input  logic             swi_req,
    input  logic             mask_i,
    input  logic             mask_x,
    output logic             take,
    output logic [SRC_W-1:0] src_idx
);
    import irqseq_pkg::*;

    // Scan from the lowest priority upward so the last hit wins.
    always_comb begin
        take    = 1'b0;
        src_idx = '0;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (irq_req[i] && irq_en[i] && !mask_i) begin
                take    = 1'b1;
                src_idx = SRC_W'(SRC_IRQ0 + i);
            end
        end
        if (swi_req) begin
            take    = 1'b1;
            src_idx = SRC_W'(SRC_SWI);
        end
        if (illop_req) begin
            take    = 1'b1;
            src_idx = SRC_W'(SRC_ILL);
        end
        if (xirq_req && !mask_x) begin
            take    = 1'b1;
            src_idx = SRC_W'(SRC_XIRQ);
        end
    end

    // R6
    take_src_chk: assert final (!take || (int'(src_idx) < N_IRQ + SRC_IRQ0));
endmodule

// File: rtl/irqseq_vec.sv
module irqseq_vec #(
    parameter int               AW       = 16,
    parameter int               SRC_W    = 4,
    parameter logic [AW-1:0]    VEC_BASE = 16'hFFC0
) (
    input  logic [SRC_W-1:0] src_idx,
    input  logic             low_half,
    output logic [AW-1:0]    vec_addr
);
    always_comb begin
        vec_addr = VEC_BASE + AW'({src_idx, low_half});
    end
endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq #(
    parameter int            N_IRQ    = 8,
    parameter int            AW       = 16,
    parameter logic [AW-1:0] VEC_BASE = 16'hFFC0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             xirq_req,
    input  logic             illop_req,
    input  logic             swi_req,
    input  logic             insn_done,
    input  logic             rti_cmd,
    input  logic [15:0]      pc_in,
    input  logic [15:0]      iy_in,
    input  logic [15:0]      ix_in,
    input  logic [7:0]       a_in,
    input  logic [7:0]       b_in,
    input  logic [7:0]       ccr_in,
    input  logic [AW-1:0]    sp_in,
    output logic [AW-1:0]    mem_addr,
    output logic [7:0]       mem_wdata,
    output logic             mem_we,
    output logic             mem_re,
    input  logic [7:0]       mem_rdata,
    output logic             busy,
    output logic             reg_load,
    output logic [15:0]      pc_out,
    output logic [15:0]      iy_out,
    output logic [15:0]      ix_out,
    output logic [7:0]       a_out,
    output logic [7:0]       b_out,
    output logic [7:0]       ccr_out,
    output logic [AW-1:0]    sp_out
);
    import irqseq_pkg::*;

    localparam int SRC_W  = $clog2(N_IRQ + SRC_IRQ0);
    localparam int CNT_W  = $clog2(FRAME_BYTES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BYTES - 1);

    typedef struct packed {
        seq_st_e                         st;
        logic [CNT_W-1:0]                cnt;
        logic [SRC_W-1:0]                src;
        logic [AW-1:0]                   sp;
        logic [FRAME_BYTES-1:0][7:0]     frame;
        logic                            load;
    } seq_t;

    seq_t r_d, r_q;

    logic             arb_take;
    logic [SRC_W-1:0] arb_src;
    logic [AW-1:0]    vec_addr;
    logic [FRAME_BYTES-1:0][7:0] in_frame;

    irqseq_arb #(.N_IRQ(N_IRQ), .SRC_W(SRC_W)) u_arb (
        .irq_req  (irq_req),
        .irq_en   (irq_en),
        .xirq_req (xirq_req),
        .illop_req(illop_req),
        .swi_req  (swi_req),
        .mask_i   (ccr_in[CCR_I]),
        .mask_x   (ccr_in[CCR_X]),
        .take     (arb_take),
        .src_idx  (arb_src)
    );

    irqseq_vec #(.AW(AW), .SRC_W(SRC_W), .VEC_BASE(VEC_BASE)) u_vec (
        .src_idx (r_q.src),
        .low_half(r_q.cnt[0]),
        .vec_addr(vec_addr)
    );

    // Byte k of the frame is the k-th byte pushed.
    assign in_frame = {ccr_in, b_in, a_in, ix_in[15:8], ix_in[7:0],
                       iy_in[15:8], iy_in[7:0], pc_in[15:8], pc_in[7:0]};

    always_comb begin
        r_d       = r_q;
        r_d.load  = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (rti_cmd) begin
                    r_d.st    = ST_PULL;
                    r_d.cnt   = '0;
                    r_d.sp    = sp_in;
                    r_d.frame = in_frame;
                end else if (insn_done && arb_take) begin
                    r_d.st    = ST_PUSH;
                    r_d.cnt   = '0;
                    r_d.src   = arb_src;
                    r_d.sp    = sp_in;
                    r_d.frame = in_frame;
                end
            end
            ST_PUSH: begin
                mem_we    = 1'b1;
                mem_addr  = r_q.sp - AW'(r_q.cnt);
                mem_wdata = r_q.frame[r_q.cnt];
                if (r_q.cnt == LAST) begin
                    r_d.frame[FB_CCR][CCR_I] = 1'b1;
                    if (r_q.src == SRC_W'(SRC_XIRQ)) begin
                        r_d.frame[FB_CCR][CCR_X] = 1'b1;
                    end
                    r_d.sp  = r_q.sp - AW'(FRAME_BYTES);
                    r_d.st  = ST_VEC;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_VEC: begin
                mem_re   = 1'b1;
                mem_addr = vec_addr;
                if (r_q.cnt[0] == 1'b0) begin
                    r_d.frame[FB_PCH] = mem_rdata;
                    r_d.cnt           = r_q.cnt + 1'b1;
                end else begin
                    r_d.frame[FB_PCL] = mem_rdata;
                    r_d.st            = ST_IDLE;
                    r_d.load          = 1'b1;
                end
            end
            ST_PULL: begin
                mem_re   = 1'b1;
                mem_addr = r_q.sp + AW'(r_q.cnt) + AW'(1);
                r_d.frame[LAST - r_q.cnt] = mem_rdata;
                if (r_q.cnt == LAST) begin
                    r_d.sp   = r_q.sp + AW'(FRAME_BYTES);
                    r_d.st   = ST_IDLE;
                    r_d.load = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.st != ST_IDLE);
    assign reg_load = r_q.load;
    assign pc_out   = {r_q.frame[1], r_q.frame[0]};
    assign iy_out   = {r_q.frame[3], r_q.frame[2]};
    assign ix_out   = {r_q.frame[5], r_q.frame[4]};
    assign a_out    = r_q.frame[6];
    assign b_out    = r_q.frame[7];
    assign ccr_out  = r_q.frame[8];
    assign sp_out   = r_q.sp;

    // R11
    bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re));
    // R4
    push_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PUSH && r_q.cnt != '0) |-> mem_addr == $past(mem_addr) - AW'(1));
    // R9
    pull_asc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PULL && r_q.cnt != '0) |-> mem_addr == $past(mem_addr) + AW'(1));
    // R5
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_VEC) |-> ccr_out[CCR_I]);
    // R8
    load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_load |=> !reg_load);
endmodule

// File: tb/sim_irq_stack_seq.sv
`timescale 1ns/1ps
module sim_irq_stack_seq;
    localparam int N = 8;
    localparam logic [15:0] VB = 16'hFFC0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] irq_req = '0, irq_en = '0;
    logic xirq_req = 0, illop_req = 0, swi_req = 0, insn_done = 0, rti_cmd = 0;
    logic [15:0] pc_in = '0, iy_in = '0, ix_in = '0, sp_in = '0;
    logic [7:0] a_in = '0, b_in = '0, ccr_in = '0;
    logic [15:0] mem_addr, pc_out, iy_out, ix_out, sp_out;
    logic [7:0] mem_wdata, mem_rdata, a_out, b_out, ccr_out;
    logic mem_we, mem_re, busy, reg_load;

    int checks = 0, errors = 0, cycles = 0;
    logic [7:0] mem [256];
    logic [15:0] wa [1024];
    logic [7:0]  wd [1024];
    logic [15:0] ra [1024];
    int wn = 0, rn = 0;

    always #5 clk = ~clk;

    irq_stack_seq #(.N_IRQ(N), .AW(16), .VEC_BASE(VB)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
        .xirq_req(xirq_req), .illop_req(illop_req), .swi_req(swi_req),
        .insn_done(insn_done), .rti_cmd(rti_cmd), .pc_in(pc_in), .iy_in(iy_in),
        .ix_in(ix_in), .a_in(a_in), .b_in(b_in), .ccr_in(ccr_in), .sp_in(sp_in),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .busy(busy), .reg_load(reg_load), .pc_out(pc_out),
        .iy_out(iy_out), .ix_out(ix_out), .a_out(a_out), .b_out(b_out),
        .ccr_out(ccr_out), .sp_out(sp_out));

    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            wa[wn] <= mem_addr; wd[wn] <= mem_wdata; wn <= wn + 1;
        end
        if (mem_re) begin
            ra[rn] <= mem_addr; rn <= rn + 1;
        end
    end

    function automatic logic [7:0] vhi(int k); return 8'(8'hA0 + k); endfunction
    function automatic logic [7:0] vlo(int k); return 8'(k * 16 + 5); endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
            finish_sim();
        end
    end

    task automatic set_regs(input logic [15:0] pc, iy, ix, input logic [7:0] a, b, ccr, input logic [15:0] sp);
        pc_in = pc; iy_in = iy; ix_in = ix; a_in = a; b_in = b; ccr_in = ccr; sp_in = sp;
    endtask

    task automatic clear_reqs();
        irq_req = '0; irq_en = '0; xirq_req = 0; illop_req = 0; swi_req = 0;
    endtask

    // Pulse a command for one cycle, then count busy cycles until reg_load.
    task automatic run_seq(input bit use_rti, input bit use_done, output int nbusy);
        int guard = 0;
        nbusy = 0;
        @(negedge clk);
        rti_cmd = use_rti; insn_done = use_done;
        @(negedge clk);
        rti_cmd = 0; insn_done = 0;
        while (!reg_load && guard < 40) begin
            if (busy) nbusy++;
            guard++;
            @(negedge clk);
        end
    endtask

    function automatic logic [7:0] frame_byte(int k);
        case (k)
            0: return pc_in[7:0];   1: return pc_in[15:8];
            2: return iy_in[7:0];   3: return iy_in[15:8];
            4: return ix_in[7:0];   5: return ix_in[15:8];
            6: return a_in;         7: return b_in;
            default: return ccr_in;
        endcase
    endfunction

    task automatic entry_case(input string tag, input int src, input bit xset);
        int nb; int w0 = wn; int r0 = rn;
        logic [7:0] expccr;
        run_seq(0, 1, nb);
        chk(nb == 11, {tag, " R11 busy length"}, nb, 11);
        chk(wn - w0 == 9, {tag, " R4 write count"}, wn - w0, 9);
        for (int k = 0; k < 9; k++) begin
            chk(wa[w0+k] == sp_in - 16'(k) && wd[w0+k] == frame_byte(k),
                {tag, " R4 push byte"}, {wa[w0+k], 8'h0, wd[w0+k]},
                {sp_in - 16'(k), 8'h0, frame_byte(k)});
        end
        chk(rn - r0 == 2 && ra[r0] == VB + 16'(2*src) && ra[r0+1] == VB + 16'(2*src+1),
            {tag, " R7 vector addresses"}, ra[r0], VB + 16'(2*src));
        chk(pc_out == {vhi(src), vlo(src)}, {tag, " R6 R7 vector pc"}, pc_out, {vhi(src), vlo(src)});
        expccr = ccr_in | 8'h10 | (xset ? 8'h40 : 8'h00);
        chk(ccr_out == expccr, {tag, " R5 mask bits"}, ccr_out, expccr);
        chk(sp_out == sp_in - 16'd9 && ix_out == ix_in && iy_out == iy_in && a_out == a_in && b_out == b_in,
            {tag, " R8 registers"}, sp_out, sp_in - 16'd9);
        @(negedge clk);
        chk(!reg_load, {tag, " R8 load pulse width"}, reg_load, 0);
    endtask

    task automatic expect_idle(input string tag, input int n);
        int seen = 0; int w0 = wn;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (busy) seen++;
        end
        chk(seen == 0 && wn == w0, tag, seen, 0);
    endtask

    task automatic t_reset();
        chk(!busy && !reg_load && !mem_we && !mem_re, "R11 reset state", {busy, reg_load, mem_we, mem_re}, 0);
    endtask

    task automatic t_maskable();
        set_regs(16'h1234, 16'h5678, 16'h9ABC, 8'h11, 8'h22, 8'h0A, 16'h0050);
        irq_req[3] = 1; irq_en[3] = 1;
        entry_case("maskable", 6, 0);
        clear_reqs();
    endtask

    task automatic t_masked();
        set_regs(16'h2000, 16'h0, 16'h0, 8'h0, 8'h0, 8'h10, 16'h0050);
        irq_req = 8'hFF; irq_en = 8'hFF;
        @(negedge clk); insn_done = 1; @(negedge clk); insn_done = 0;
        expect_idle("R1 I bit blocks maskable", 4);
        ccr_in = 8'h00; irq_en = 8'h00;
        @(negedge clk); insn_done = 1; @(negedge clk); insn_done = 0;
        expect_idle("R1 local enable blocks", 4);
        clear_reqs();
    endtask

    task automatic t_no_boundary();
        set_regs(16'h3000, 16'h0, 16'h0, 8'h0, 8'h0, 8'h00, 16'h0050);
        swi_req = 1;
        expect_idle("R3 no entry without boundary", 6);
        clear_reqs();
    endtask

    task automatic t_priority();
        set_regs(16'h4000, 16'h1111, 16'h2222, 8'h33, 8'h44, 8'h00, 16'h0060);
        irq_req[1] = 1; irq_req[5] = 1; irq_en = 8'hFF;
        entry_case("irq1 over irq5 R6", 4, 0);
        clear_reqs();
        ccr_in = 8'h10;
        irq_req[0] = 1; irq_en[0] = 1; swi_req = 1;
        entry_case("swi with I set R2", 2, 0);
        illop_req = 1;
        entry_case("illegal over swi R6", 1, 0);
        clear_reqs();
    endtask

    task automatic t_xirq();
        set_regs(16'h5000, 16'hAAAA, 16'hBBBB, 8'h01, 8'h02, 8'h10, 16'h0050);
        xirq_req = 1; illop_req = 1;
        entry_case("xirq R2 R5", 0, 1);
        ccr_in = 8'h40; illop_req = 0;
        @(negedge clk); insn_done = 1; @(negedge clk); insn_done = 0;
        expect_idle("R2 X bit blocks xirq", 4);
        clear_reqs();
    endtask

    task automatic t_midseq();
        int nb;
        set_regs(16'h6000, 16'h0102, 16'h0304, 8'h05, 8'h06, 8'h00, 16'h0050);
        irq_req[2] = 1; irq_en[2] = 1;
        @(negedge clk); insn_done = 1; @(negedge clk); insn_done = 0;
        repeat (3) @(negedge clk);
        xirq_req = 1;
        while (!reg_load) @(negedge clk);
        chk(pc_out == {vhi(5), vlo(5)}, "R3 late xirq does not change vector", pc_out, {vhi(5), vlo(5)});
        chk(ccr_out[6] == 0, "R5 X stays clear for maskable", ccr_out, 8'h10);
        expect_idle("R3 late request waits for boundary", 5);
        irq_req = '0;
        run_seq(0, 1, nb);
        chk(pc_out == {vhi(0), vlo(0)}, "R3 held xirq taken at next boundary", pc_out, {vhi(0), vlo(0)});
        clear_reqs();
    endtask

    task automatic t_roundtrip();
        int nb; int r0;
        set_regs(16'hBEEF, 16'hCAFE, 16'hF00D, 8'h5A, 8'hA5, 8'h03, 16'h0050);
        swi_req = 1;
        entry_case("roundtrip entry", 2, 0);
        clear_reqs();
        sp_in = 16'h0047; ccr_in = 8'h13;
        r0 = rn;
        run_seq(1, 0, nb);
        chk(nb == 9, "R11 pull busy length", nb, 9);
        for (int k = 0; k < 9; k++) begin
            chk(ra[r0+k] == 16'h0048 + 16'(k), "R9 pull address", ra[r0+k], 16'h0048 + 16'(k));
        end
        chk(pc_out == 16'hBEEF && iy_out == 16'hCAFE && ix_out == 16'hF00D,
            "R9 pointers restored", pc_out, 16'hBEEF);
        chk(a_out == 8'h5A && b_out == 8'hA5 && ccr_out == 8'h03,
            "R9 bytes restored", {a_out, b_out, ccr_out}, 24'h5AA503);
        chk(sp_out == 16'h0050, "R9 sp restored", sp_out, 16'h0050);
    endtask

    task automatic t_rti_wins();
        int nb; int w0 = wn; int r0 = rn;
        set_regs(16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 8'h00, 16'h0047);
        swi_req = 1;
        run_seq(1, 1, nb);
        chk(wn == w0 && rn - r0 == 9, "R10 return wins over entry", wn - w0, 0);
        clear_reqs();
    endtask

    initial begin
        for (int k = 0; k < N + 3; k++) begin
            mem[8'(VB[7:0] + 8'(2*k))]     = vhi(k);
            mem[8'(VB[7:0] + 8'(2*k + 1))] = vlo(k);
        end
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        repeat (2) @(negedge clk);
        t_maskable();
        t_masked();
        t_no_boundary();
        t_priority();
        t_xirq();
        t_midseq();
        t_roundtrip();
        t_rti_wins();
        repeat (3) @(negedge clk);
        finish_sim();
    end
endmodule